// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator

This block sits between a PWM duty comparator and the gate-drive pins of a half bridge. It takes one raw PWM waveform and produces a high-side and a low-side drive signal. In complementary mode the low side is the inverse of the raw waveform. Each side's turn-on edge is held back by a programmable dead time, so the two switches are never driven together. Two dead-time values exist, a primary and an alternate. A negative-mode control exchanges which side each value applies to.

The block also offers two other output modes. Push-pull steers whole raw pulses to the two sides in turn, one PWM period at a time. True independent mode lets each side follow its own raw input. All delays are counted in ticks of the divided clock enable that drives the time base. After the dead-time stage, an optional high/low swap and a per-pin polarity inversion shape the final pins.

Two state machines carry the timing. The first is the edge-delay machine, one per side:
- EDGE_IDLE: the side is off. A sampled high reference moves it to EDGE_ARM and loads the counter, or straight to EDGE_ON when the delay is zero.
- EDGE_ARM: the side is counting. A low reference drops it back to EDGE_IDLE. Expiry moves it to EDGE_ON. Otherwise it decrements.
- EDGE_ON: the side drives high. A low reference returns it to EDGE_IDLE.

The second is the push-pull steering machine, with states PP_LOW and PP_HIGH. It toggles on every ticked period-start pulse.

Top module: `dtgen_top`

## Requirements
- R1: While reset is asserted, both dead-time outputs are low. Each pin therefore shows its polarity bit: pwm_hi_o equals pol_hi_i and pwm_lo_o equals pol_lo_i. The push-pull steering machine resets to PP_LOW.
- R2: In complementary mode (mode_i = 2'b00) with neg_dt_i = 0, the high side rises dt_pri_i ticks after a raw rising edge is first sampled. The low side rises dt_alt_i ticks after a raw falling edge is first sampled. The side whose reference falls drops at the tick that samples that edge. This holds up to the 14-bit maximum of 16383.
- R3: With neg_dt_i = 1 in complementary mode, dt_alt_i delays the high side and dt_pri_i delays the low side.
- R4: In complementary mode, after any tick both dead-time outputs are never high together.
- R5: If a side's reference returns low before its count expires, that side stays low. The next rising reference restarts the full count.
- R6: A dead-time value of zero makes a side follow its reference at the very tick that samples it.
- R7: In push-pull mode (mode_i = 2'b01), each ticked period_start_i flips the steering side. The raw pulse of the first period after reset goes to the high side and the next period's pulse goes to the low side. The other side stays low, and no dead time applies.
- R8: In true independent mode (mode_i = 2'b10), after each tick the high side equals raw_a_i and the low side equals raw_b_i, as sampled at that tick.
- R9: pol_hi_i = 1 inverts pwm_hi_o and pol_lo_i = 1 inverts pwm_lo_o; inversion takes effect without waiting for a tick.
- R10: swap_i = 1 sends the high-side dead-time output to pwm_lo_o and the low-side one to pwm_hi_o. The swap happens before polarity, so polarity stays tied to the pin.
- R11: State advances only in cycles where tick_en_i is high, so every delay is counted in ticks rather than clock cycles.
- R12: With mode_i = 2'b11 (off), both dead-time outputs go low at the next tick, whatever the raw inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Divided-clock enable; one time-base tick |
| mode_i | input | 2 | 00 complementary, 01 push-pull, 10 independent, 11 off |
| neg_dt_i | input | 1 | 1 exchanges the dead-time values between the sides |
| dt_pri_i | input | DT_W | Primary dead time in ticks |
| dt_alt_i | input | DT_W | Alternate dead time in ticks |
| raw_a_i | input | 1 | Raw PWM waveform |
| raw_b_i | input | 1 | Second raw waveform, low side in independent mode |
| period_start_i | input | 1 | Start-of-period pulse for push-pull steering |
| pol_hi_i | input | 1 | Invert the high pin |
| pol_lo_i | input | 1 | Invert the low pin |
| swap_i | input | 1 | Exchange the high and low signals |
| pwm_hi_o | output | 1 | High-side pin |
| pwm_lo_o | output | 1 | Low-side pin |

## Verification
The assertions take for granted that the dead-time values, neg_dt_i and mode_i hold still while an edge count is in flight. Otherwise a countdown step could observe a reloaded delay. The overlap and follow properties judge only the tick that comes after a mode has been applied. The stimulus changes configuration only after the raw inputs have been low for longer than the largest delay in use. It keeps every delay constant across a pulse train. It drives all inputs half a cycle away from the sampling edge, including irregular tick patterns.

// File: rtl/dtgen_pkg.sv
package dtgen_pkg;

    typedef enum logic [1:0] {
        OUT_COMP     = 2'b00,
        OUT_PUSHPULL = 2'b01,
        OUT_INDEP    = 2'b10,
        OUT_OFF      = 2'b11
    } out_mode_e;

    typedef enum logic [1:0] {
        EDGE_IDLE = 2'b00,
        EDGE_ARM  = 2'b01,
        EDGE_ON   = 2'b10
    } edge_state_e;

    typedef enum logic {
        PP_LOW  = 1'b0,
        PP_HIGH = 1'b1
    } pp_side_e;

endpackage

// File: rtl/dtgen_edge_delay.sv
module dtgen_edge_delay
    import dtgen_pkg::*;
#(
    parameter int DT_W = 14
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tick_i,
    input  logic            ref_i,
    input  logic [DT_W-1:0] delay_i,
    output logic            on_o
);

    localparam logic [DT_W-1:0] CNT_ONE = {{(DT_W-1){1'b0}}, 1'b1};

    edge_state_e     state_q, state_d;
    logic [DT_W-1:0] cnt_q, cnt_d;
    logic            dly_zero;
    logic            cnt_last;

    assign dly_zero = (delay_i == '0);
    assign cnt_last = (cnt_q <= CNT_ONE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (tick_i) begin
            unique case (state_q)
                EDGE_IDLE: begin
                    if (ref_i) begin
                        if (dly_zero) begin
                            state_d = EDGE_ON;
                        end else begin
                            state_d = EDGE_ARM;
                            cnt_d   = delay_i;
                        end
                    end
                end
                EDGE_ARM: begin
                    if (!ref_i) begin
                        state_d = EDGE_IDLE;
                    end else if (cnt_last || dly_zero) begin
                        state_d = EDGE_ON;
                    end else begin
                        cnt_d = cnt_q - CNT_ONE;
                    end
                end
                EDGE_ON: begin
                    if (!ref_i) begin
                        state_d = EDGE_IDLE;
                    end
                end
                default: state_d = EDGE_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= EDGE_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        on_o = (state_q == EDGE_ON);
    end

    p_fall_on_ref_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && state_q == EDGE_ON && !ref_i) |=> !on_o);

    p_count_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && state_q == EDGE_ARM && ref_i && !cnt_last && !dly_zero)
        |=> (state_q == EDGE_ARM) && (cnt_q == $past(cnt_q) - CNT_ONE));

    p_zero_delay_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && state_q == EDGE_IDLE && ref_i && dly_zero) |=> on_o);

    p_hold_no_tick_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> ($stable(state_q) && $stable(cnt_q)));

endmodule

// File: rtl/dtgen_pp_steer.sv
module dtgen_pp_steer
    import dtgen_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     tick_i,
    input  logic     period_start_i,
    output pp_side_e side_o
);

    pp_side_e side_q, side_d;
    pp_side_e side_now;

    // the period that starts now already uses the new side
    always_comb begin
        side_now = side_q;
        if (period_start_i) begin
            unique case (side_q)
                PP_LOW:  side_now = PP_HIGH;
                PP_HIGH: side_now = PP_LOW;
                default: side_now = PP_HIGH;
            endcase
        end
        side_d = tick_i ? side_now : side_q;
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            side_q <= PP_LOW;
        end else begin
            side_q <= side_d;
        end
    end

    // outputs
    always_comb begin
        side_o = side_now;
    end

    p_toggle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && period_start_i) |=> (side_q != $past(side_q)));

    p_steady_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(tick_i && period_start_i) |=> $stable(side_q));

endmodule

// File: rtl/dtgen_pin_stage.sv
module dtgen_pin_stage (
    input  logic a_hi_i,
    input  logic a_lo_i,
    input  logic swap_i,
    input  logic pol_hi_i,
    input  logic pol_lo_i,
    output logic pin_hi_o,
    output logic pin_lo_o
);

    logic route_hi;
    logic route_lo;

    always_comb begin
        route_hi = swap_i ? a_lo_i : a_hi_i;
        route_lo = swap_i ? a_hi_i : a_lo_i;
        pin_hi_o = route_hi ^ pol_hi_i;
        pin_lo_o = route_lo ^ pol_lo_i;
    end

endmodule

// File: rtl/dtgen_top.sv
module dtgen_top
    import dtgen_pkg::*;
#(
    parameter int DT_W = 14
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tick_en_i,
    input  logic [1:0]      mode_i,
    input  logic            neg_dt_i,
    input  logic [DT_W-1:0] dt_pri_i,
    input  logic [DT_W-1:0] dt_alt_i,
    input  logic            raw_a_i,
    input  logic            raw_b_i,
    input  logic            period_start_i,
    input  logic            pol_hi_i,
    input  logic            pol_lo_i,
    input  logic            swap_i,
    output logic            pwm_hi_o,
    output logic            pwm_lo_o
);

    localparam int NCH    = 2;
    localparam int IDX_HI = 0;
    localparam int IDX_LO = 1;

    out_mode_e       mode_e;
    pp_side_e        pp_side;
    logic            ref_v [NCH];
    logic [DT_W-1:0] dly_v [NCH];
    logic            dt_v  [NCH];

    assign mode_e = out_mode_e'(mode_i);

    dtgen_pp_steer u_steer (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .tick_i         (tick_en_i),
        .period_start_i (period_start_i),
        .side_o         (pp_side)
    );

    // reference and delay selection per output mode
    always_comb begin
        ref_v[IDX_HI] = 1'b0;
        ref_v[IDX_LO] = 1'b0;
        dly_v[IDX_HI] = '0;
        dly_v[IDX_LO] = '0;
        unique case (mode_e)
            OUT_COMP: begin
                ref_v[IDX_HI] = raw_a_i;
                ref_v[IDX_LO] = !raw_a_i;
                dly_v[IDX_HI] = neg_dt_i ? dt_alt_i : dt_pri_i;
                dly_v[IDX_LO] = neg_dt_i ? dt_pri_i : dt_alt_i;
            end
            OUT_PUSHPULL: begin
                ref_v[IDX_HI] = raw_a_i && (pp_side == PP_HIGH);
                ref_v[IDX_LO] = raw_a_i && (pp_side == PP_LOW);
            end
            OUT_INDEP: begin
                ref_v[IDX_HI] = raw_a_i;
                ref_v[IDX_LO] = raw_b_i;
            end
            OUT_OFF: begin
                ref_v[IDX_HI] = 1'b0;
                ref_v[IDX_LO] = 1'b0;
            end
            default: begin
                ref_v[IDX_HI] = 1'b0;
                ref_v[IDX_LO] = 1'b0;
            end
        endcase
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_side
        dtgen_edge_delay #(
            .DT_W (DT_W)
        ) u_delay (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .tick_i  (tick_en_i),
            .ref_i   (ref_v[ch]),
            .delay_i (dly_v[ch]),
            .on_o    (dt_v[ch])
        );
    end

    dtgen_pin_stage u_pins (
        .a_hi_i   (dt_v[IDX_HI]),
        .a_lo_i   (dt_v[IDX_LO]),
        .swap_i   (swap_i),
        .pol_hi_i (pol_hi_i),
        .pol_lo_i (pol_lo_i),
        .pin_hi_o (pwm_hi_o),
        .pin_lo_o (pwm_lo_o)
    );

    p_no_overlap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_en_i && mode_e == OUT_COMP) |=> !(dt_v[IDX_HI] && dt_v[IDX_LO]));

    p_indep_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_en_i && mode_e == OUT_INDEP)
        |=> (dt_v[IDX_HI] == $past(raw_a_i)) && (dt_v[IDX_LO] == $past(raw_b_i)));

    p_off_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_en_i && mode_e == OUT_OFF) |=> (!dt_v[IDX_HI] && !dt_v[IDX_LO]));

    p_pp_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_en_i && mode_e == OUT_PUSHPULL) |=> !(dt_v[IDX_HI] && dt_v[IDX_LO]));

endmodule

// File: tb/dtgen_top_tb_top.sv
module dtgen_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DT_W       = 14;
    localparam int WATCHDOG   = 200000;
    localparam int CNT_SAT    = 1 << 20;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            tick_en = 1'b0;
    logic [1:0]      mode = 2'b00;
    logic            neg_dt = 1'b0;
    logic [DT_W-1:0] dt_pri = '0;
    logic [DT_W-1:0] dt_alt = '0;
    logic            raw_a = 1'b0;
    logic            raw_b = 1'b0;
    logic            period_start = 1'b0;
    logic            pol_hi = 1'b0;
    logic            pol_lo = 1'b0;
    logic            swap = 1'b0;
    logic            pwm_hi;
    logic            pwm_lo;

    int    checks = 0;
    int    errors = 0;
    int    tick_div = 1;
    int    tick_ctr = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_cnt [2];
    int m_dly [2];
    bit m_last_hi;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtgen_top #(.DT_W(DT_W)) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .tick_en_i      (tick_en),
        .mode_i         (mode),
        .neg_dt_i       (neg_dt),
        .dt_pri_i       (dt_pri),
        .dt_alt_i       (dt_alt),
        .raw_a_i        (raw_a),
        .raw_b_i        (raw_b),
        .period_start_i (period_start),
        .pol_hi_i       (pol_hi),
        .pol_lo_i       (pol_lo),
        .swap_i         (swap),
        .pwm_hi_o       (pwm_hi),
        .pwm_lo_o       (pwm_lo)
    );

    // behavioural model: count consecutive ticks each side's request is high
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt[0] = 0; m_cnt[1] = 0;
            m_dly[0] = 0; m_dly[1] = 0;
            m_last_hi = 1'b0;
        end else if (tick_en) begin
            bit side_hi;
            bit rq [2];
            int dl [2];
            side_hi = period_start ? !m_last_hi : m_last_hi;
            dl[0] = 0; dl[1] = 0;
            case (mode)
                2'b00: begin
                    rq[0] = raw_a; rq[1] = !raw_a;
                    dl[0] = neg_dt ? int'(dt_alt) : int'(dt_pri);
                    dl[1] = neg_dt ? int'(dt_pri) : int'(dt_alt);
                end
                2'b01: begin rq[0] = raw_a && side_hi; rq[1] = raw_a && !side_hi; end
                2'b10: begin rq[0] = raw_a; rq[1] = raw_b; end
                default: begin rq[0] = 1'b0; rq[1] = 1'b0; end
            endcase
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = rq[i] ? ((m_cnt[i] < CNT_SAT) ? m_cnt[i] + 1 : CNT_SAT) : 0;
                m_dly[i] = dl[i];
            end
            m_last_hi = side_hi;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            bit a, b, eh, el;
            a  = (m_cnt[0] > m_dly[0]);
            b  = (m_cnt[1] > m_dly[1]);
            eh = (swap ? b : a) ^ pol_hi;
            el = (swap ? a : b) ^ pol_lo;
            checks += 2;
            if (pwm_hi !== eh) begin
                errors++;
                $display("FAIL %s pwm_hi actual=%b expected=%b t=%0t", cur_req, pwm_hi, eh, $time);
            end
            if (pwm_lo !== el) begin
                errors++;
                $display("FAIL %s pwm_lo actual=%b expected=%b t=%0t", cur_req, pwm_lo, el, $time);
            end
            if (rst_n && mode == 2'b00 && !pol_hi && !pol_lo) begin
                checks++;
                if (pwm_hi && pwm_lo) begin
                    errors++;
                    $display("FAIL R4 overlap actual=11 expected=not_both t=%0t", $time);
                end
            end
        end
    end

    task automatic cyc();
        @(negedge clk);
        #1;
        tick_ctr++;
        tick_en = ((tick_ctr % tick_div) == 0);
    endtask

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic pulse(int hi_n, int lo_n);
        raw_a = 1'b1;
        wait_cyc(hi_n);
        raw_a = 1'b0;
        wait_cyc(lo_n);
    endtask

    task automatic pp_period(int hi_n, int len);
        period_start = 1'b1;
        raw_a = 1'b1;
        cyc();
        period_start = 1'b0;
        wait_cyc(hi_n - 1);
        raw_a = 1'b0;
        wait_cyc(len - hi_n);
    endtask

    initial begin
        rst_n = 1'b0;
        // R1: reset state, polarity visible on the pins
        cur_req = "R1";
        pol_hi = 1'b1;
        wait_cyc(4);
        pol_hi = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;

        // R2: complementary, positive dead time
        cur_req = "R2";
        dt_pri = 14'd3; dt_alt = 14'd5;
        wait_cyc(10);
        pulse(10, 12); pulse(7, 9); pulse(20, 15);

        // R3: negative dead time exchanges the values
        cur_req = "R3";
        neg_dt = 1'b1;
        wait_cyc(10);
        pulse(10, 12); pulse(8, 8);
        neg_dt = 1'b0;
        wait_cyc(10);

        // R5: pulses shorter than the pending count
        cur_req = "R5";
        dt_pri = 14'd6; dt_alt = 14'd4;
        wait_cyc(10);
        pulse(3, 2); pulse(5, 3); pulse(12, 12);

        // R6: zero dead time
        cur_req = "R6";
        dt_pri = 14'd0; dt_alt = 14'd0;
        wait_cyc(4);
        pulse(1, 1); pulse(4, 3); pulse(2, 5);

        // R11: ticks every other or every third cycle
        cur_req = "R11";
        dt_pri = 14'd3; dt_alt = 14'd2;
        wait_cyc(8);
        tick_div = 2;
        pulse(15, 14); pulse(5, 20);
        tick_div = 3;
        pulse(20, 25);
        tick_div = 1;
        wait_cyc(10);

        // R2 boundary: largest 14-bit delay
        cur_req = "R2";
        dt_pri = 14'd16383; dt_alt = 14'd1;
        wait_cyc(4);
        pulse(16390, 10);
        dt_pri = 14'd2;
        wait_cyc(10);

        // R7: push-pull steering
        cur_req = "R7";
        mode = 2'b01;
        wait_cyc(4);
        pp_period(5, 12); pp_period(3, 12); pp_period(6, 10); pp_period(4, 10);

        // R8: true independent
        cur_req = "R8";
        mode = 2'b10;
        wait_cyc(4);
        for (int i = 0; i < 40; i++) begin
            raw_a = ((i % 3) == 0);
            raw_b = ((i % 5) < 2);
            cyc();
        end
        raw_a = 1'b0; raw_b = 1'b0;
        wait_cyc(4);

        // R12: off mode
        cur_req = "R12";
        mode = 2'b11;
        raw_b = 1'b1;
        pulse(6, 4); pulse(3, 3);
        raw_b = 1'b0;
        wait_cyc(4);

        // R9: polarity inversion
        cur_req = "R9";
        mode = 2'b00;
        dt_pri = 14'd2; dt_alt = 14'd3;
        wait_cyc(8);
        pol_hi = 1'b1; pol_lo = 1'b1;
        pulse(9, 9); pulse(5, 7);
        pol_lo = 1'b0;
        pulse(6, 8);

        // R10: swap, polarity stays on the pin
        cur_req = "R10";
        swap = 1'b1;
        pulse(9, 9); pulse(6, 10);
        pol_hi = 1'b0; pol_lo = 1'b1;
        pulse(7, 9);
        swap = 1'b0; pol_lo = 1'b0;
        wait_cyc(4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog %s actual=running expected=finished", cur_req);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule